// File: doc/BRIEF.md
# ATM Receive Port Cell Gate

One ATM receive port sits between a framer receive interface, which delivers already delineated 53-byte cells with a start-of-cell marker, and a receive cell buffer plus its output queue. For each cell it decides whether to write it and announce it. The port mode gates this choice. Inactive ignores the line entirely. Standby follows cell boundaries but stores nothing, which is useful when testing delineation. Active writes every byte into a buffer slot and pushes the slot number into the output queue when the cell completes.

A header filter can delete idle, physical-layer and unassigned cells. The cell is deleted when deletion is enabled, the first three header octets are zero, and the fourth octet matches a pattern under a bit mask. A deleted cell is never queued, and its slot is reused. An activation sequencer guards entry to Active. The port-active bit must have been held high for a minimum time, counted in clock cycles from a clock-frequency parameter, before a write of an Active mode is accepted. An early request raises an error flag and leaves the mode unchanged.

Top module: `atm_rx_cell_gate`

## Requirements
- R1: After reset no buffer write and no queue push is issued, `mode_o` is 00 and `act_err_o` is 0.
- R2: A mode write (`mode_wr_i` high) decodes `mode_i` as follows: 00 is Inactive, 01 and 11 are Active, and 10 is Standby. `mode_o` reports 00 for Inactive, 01 for Active and 10 for Standby, and never reports 11.
- R3: In Inactive mode all framer bytes are ignored: no buffer write, no queue push, and no change to the slot that the next cell stored in Active will use.
- R4: In Active mode, every byte of a cell is written one cycle after it is accepted. The write address is `{slot, byte_index}`, with the byte index in the low 6 bits and byte 0 being the start-of-cell byte.
- R5: A kept Active cell pushes its slot number one cycle after its 53rd byte, in the same cycle as that byte's write. Slots then advance by one, modulo `SLOTS`.
- R6: In Standby mode cells are followed but no buffer write and no queue push occur.
- R7: When `del_en_i` is 1, a cell whose header octets 0..2 are zero and whose octet 3 satisfies `(octet3 & hdr_mask_i) == (hdr_pat_i & hdr_mask_i)` is not pushed, and the next kept cell reuses its slot. A mask bit of 1 means the bit is compared.
- R8: When `del_en_i` is 0, no cell is deleted by the header filter.
- R9: The hold counter runs while `port_act_i` is 1. A write of an Active mode is accepted only once `port_act_i` has been 1 for `CLK_MHZ*HOLD_US` clock edges. An earlier Active write sets `act_err_o` and leaves the mode unchanged.
- R10: While `port_act_i` is 0, the mode is forced to Inactive, the hold counter and `act_err_o` are cleared, and mode writes have no effect.
- R11: The mode in force at a cell's start-of-cell byte governs the whole cell. A mode change in the middle of a cell takes effect from the next start-of-cell.
- R12: A start-of-cell marker in the middle of a cell abandons the partial cell, and the new byte becomes byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_act_i | input | 1 | Port-active bit of the activation sequence |
| mode_wr_i | input | 1 | Strobe that writes `mode_i` |
| mode_i | input | 2 | Requested channel mode field |
| del_en_i | input | 1 | Enables header-filter deletion |
| hdr_mask_i | input | 8 | Compare mask for header octet 3 |
| hdr_pat_i | input | 8 | Compare pattern for header octet 3 |
| rx_valid_i | input | 1 | Framer byte valid |
| rx_soc_i | input | 1 | Start-of-cell marker |
| rx_data_i | input | 8 | Framer byte |
| buf_we_o | output | 1 | Buffer byte write enable |
| buf_addr_o | output | SLOT_W+6 | Buffer byte address {slot, byte index} |
| buf_data_o | output | 8 | Buffer byte data |
| q_push_o | output | 1 | Output-queue push |
| q_addr_o | output | SLOT_W | Slot number pushed to the queue |
| mode_o | output | 2 | Mode in force (00/01/10) |
| act_err_o | output | 1 | Early activation error, sticky |

## Verification
The bench builds the block with `CLK_MHZ=1` and `HOLD_US=16`, which gives a 16-cycle hold. This puts the exact boundary of the activation window within reach: a request one edge early is refused and the next one is accepted. `SLOTS=4` lets the slot pointer wrap after a few cells, so the wrap, and slot reuse after a deleted cell, are both observed at the queue port.

// File: rtl/atm_rx_gate_pkg.sv
package atm_rx_gate_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ON   = 2'b01,
    MODE_STBY = 2'b10
  } port_mode_e;

  localparam int CELL_BYTES = 53;
  localparam int BIDX_W     = 6;
  localparam int HDR_BYTES  = 4;

  function automatic port_mode_e decode_mode(input logic [1:0] fld);
    case (fld)
      2'b00:   return MODE_OFF;
      2'b10:   return MODE_STBY;
      default: return MODE_ON;
    endcase
  endfunction
endpackage

// File: rtl/rx_act_seq.sv
module rx_act_seq
  import atm_rx_gate_pkg::*;
#(
  parameter int HOLD_CYC = 25000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       port_act_i,
  input  logic       mode_wr_i,
  input  logic [1:0] mode_i,
  output port_mode_e mode_o,
  output logic       err_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;
  port_mode_e       mode_q;
  logic             err_q;
  logic             hold_done;
  port_mode_e       req_mode;

  assign hold_done = (cnt_q == HOLD_C);
  assign req_mode  = decode_mode(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_OFF;
      err_q  <= 1'b0;
    end else if (!port_act_i) begin
      cnt_q  <= '0;
      mode_q <= MODE_OFF;
      err_q  <= 1'b0;
    end else begin
      if (!hold_done) cnt_q <= cnt_q + 1'b1;
      if (mode_wr_i) begin
        if (req_mode == MODE_ON && !hold_done) err_q <= 1'b1;
        else                                    mode_q <= req_mode;
      end
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rx_cell_track.sv
module rx_cell_track
  import atm_rx_gate_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   soc_i,
  input  logic [7:0]             data_i,
  input  port_mode_e             mode_i,
  output logic                   accept_o,
  output logic [BIDX_W-1:0]      idx_o,
  output logic                   last_o,
  output port_mode_e             cell_mode_o,
  output logic [HDR_BYTES-1:0][7:0] hdr_o
);
  logic              in_cell_q;
  logic [BIDX_W-1:0] idx_q;
  port_mode_e        cell_mode_q;
  logic              start, cont, kill;

  assign start = valid_i && soc_i && (mode_i != MODE_OFF);
  assign kill  = valid_i && soc_i && (mode_i == MODE_OFF);
  assign cont  = valid_i && !soc_i && in_cell_q;

  assign accept_o    = start || cont;
  assign idx_o       = start ? '0 : idx_q + 1'b1;
  assign last_o      = accept_o && (idx_o == BIDX_W'(CELL_BYTES - 1));
  assign cell_mode_o = start ? mode_i : cell_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cell_q   <= 1'b0;
      idx_q       <= '0;
      cell_mode_q <= MODE_OFF;
    end else begin
      if (accept_o) idx_q <= idx_o;
      if (start) cell_mode_q <= mode_i;
      if (last_o || kill) in_cell_q <= 1'b0;
      else if (start)     in_cell_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  hdr_o[g] <= '0;
      else if (accept_o && idx_o == BIDX_W'(g))     hdr_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/rx_hdr_filter.sv
module rx_hdr_filter
  import atm_rx_gate_pkg::*;
(
  input  logic                      del_en_i,
  input  logic [7:0]                mask_i,
  input  logic [7:0]                pat_i,
  input  logic [HDR_BYTES-1:0][7:0] hdr_i,
  output logic                      drop_o
);
  logic lead_zero;
  logic tail_hit;

  // octets 0..2 all zero marks an unassigned/idle candidate
  assign lead_zero = (hdr_i[0] | hdr_i[1] | hdr_i[2]) == 8'h00;
  assign tail_hit  = ((hdr_i[3] ^ pat_i) & mask_i) == 8'h00;
  assign drop_o    = del_en_i && lead_zero && tail_hit;
endmodule

// File: rtl/atm_rx_cell_gate.sv
module atm_rx_cell_gate
  import atm_rx_gate_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int HOLD_US = 250,
  parameter int SLOTS   = 4,
  localparam int HOLD_CYC = CLK_MHZ * HOLD_US,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int ADDR_W   = SLOT_W + BIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_act_i,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_i,
  input  logic              del_en_i,
  input  logic [7:0]        hdr_mask_i,
  input  logic [7:0]        hdr_pat_i,
  input  logic              rx_valid_i,
  input  logic              rx_soc_i,
  input  logic [7:0]        rx_data_i,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              q_push_o,
  output logic [SLOT_W-1:0] q_addr_o,
  output logic [1:0]        mode_o,
  output logic              act_err_o
);
  port_mode_e                mode_cur;
  port_mode_e                cell_mode;
  logic                      accept, last, drop, commit, wr_byte;
  logic [BIDX_W-1:0]         idx;
  logic [HDR_BYTES-1:0][7:0] hdr;
  logic [SLOT_W-1:0]         slot_q;

  rx_act_seq #(.HOLD_CYC(HOLD_CYC)) i_act_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_act_i (port_act_i),
    .mode_wr_i  (mode_wr_i),
    .mode_i     (mode_i),
    .mode_o     (mode_cur),
    .err_o      (act_err_o)
  );

  rx_cell_track i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_i),
    .soc_i       (rx_soc_i),
    .data_i      (rx_data_i),
    .mode_i      (mode_cur),
    .accept_o    (accept),
    .idx_o       (idx),
    .last_o      (last),
    .cell_mode_o (cell_mode),
    .hdr_o       (hdr)
  );

  rx_hdr_filter i_filter (
    .del_en_i (del_en_i),
    .mask_i   (hdr_mask_i),
    .pat_i    (hdr_pat_i),
    .hdr_i    (hdr),
    .drop_o   (drop)
  );

  assign wr_byte = accept && (cell_mode == MODE_ON);
  // header regs are complete long before byte 52
  assign commit  = last && (cell_mode == MODE_ON) && !drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_we_o   <= 1'b0;
      buf_addr_o <= '0;
      buf_data_o <= '0;
      q_push_o   <= 1'b0;
      q_addr_o   <= '0;
      slot_q     <= '0;
    end else begin
      buf_we_o <= wr_byte;
      q_push_o <= commit;
      if (wr_byte) begin
        buf_addr_o <= {slot_q, idx};
        buf_data_o <= rx_data_i;
      end
      if (commit) begin
        q_addr_o <= slot_q;
        slot_q   <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign mode_o = mode_cur;
endmodule

// File: rtl/atm_rx_cell_gate_chk.sv
module atm_rx_cell_gate_chk #(
  parameter int SLOT_W = 2,
  localparam int ADDR_W = SLOT_W + 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_act_i,
  input logic              mode_wr_i,
  input logic [1:0]        mode_i,
  input logic              buf_we_o,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic              q_push_o,
  input logic [SLOT_W-1:0] q_addr_o,
  input logic [1:0]        mode_o,
  input logic              act_err_o
);
  assert_push_on_last_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_push_o |-> (buf_we_o && buf_addr_o[5:0] == 6'd52 && buf_addr_o[ADDR_W-1:6] == q_addr_o));

  assert_push_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_push_o |=> !q_push_o);

  assert_mode_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  assert_port_off_forces_inactive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_act_i |=> (mode_o == 2'b00 && !act_err_o));

  assert_err_only_on_early_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_err_o) |-> ($past(mode_wr_i) && $past(mode_i[0]) && $past(port_act_i)));

  assert_active_entry_by_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && $past(mode_o) != 2'b01) |-> ($past(mode_wr_i) && $past(port_act_i)));
endmodule

bind atm_rx_cell_gate atm_rx_cell_gate_chk #(.SLOT_W(SLOT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .port_act_i (port_act_i),
  .mode_wr_i  (mode_wr_i),
  .mode_i     (mode_i),
  .buf_we_o   (buf_we_o),
  .buf_addr_o (buf_addr_o),
  .q_push_o   (q_push_o),
  .q_addr_o   (q_addr_o),
  .mode_o     (mode_o),
  .act_err_o  (act_err_o)
);

// File: tb/test_atm_rx_cell_gate.sv
module test_atm_rx_cell_gate;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int NSLOT = 4;
  localparam int SW = 2;
  localparam int AW = SW + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic port_act = 0, mode_wr = 0, del_en = 0, valid = 0, soc = 0;
  logic [1:0] mode = 0;
  logic [7:0] mask = 0, pat = 0, data = 0;
  logic buf_we, q_push, act_err;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic [SW-1:0] q_addr;
  logic [1:0] mode_o;

  int vectors = 0, miscompares = 0;
  int wr_cnt = 0, push_cnt = 0, last_push = -1, exp_slot = 0;
  logic [7:0] shadow [NSLOT*64];

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_rx_cell_gate #(.CLK_MHZ(1), .HOLD_US(HOLD), .SLOTS(NSLOT)) i_atm_rx_cell_gate (
    .clk_i(clk), .rst_ni(rst_n), .port_act_i(port_act), .mode_wr_i(mode_wr),
    .mode_i(mode), .del_en_i(del_en), .hdr_mask_i(mask), .hdr_pat_i(pat),
    .rx_valid_i(valid), .rx_soc_i(soc), .rx_data_i(data), .buf_we_o(buf_we),
    .buf_addr_o(buf_addr), .buf_data_o(buf_data), .q_push_o(q_push),
    .q_addr_o(q_addr), .mode_o(mode_o), .act_err_o(act_err));

  always @(negedge clk) if (rst_n) begin
    if (buf_we) begin wr_cnt++; shadow[buf_addr] = buf_data; end
    if (q_push) begin push_cnt++; last_push = int'(q_addr); end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); mode = m; mode_wr = 1;
    @(negedge clk); mode_wr = 0;
    #1;
  endtask

  task automatic send_cell(input logic [7:0] h0, h1, h2, h3, input logic [7:0] base,
                           input int nbytes, input int chg_at, input logic [1:0] chg_mode);
    logic [7:0] h [4];
    h[0] = h0; h[1] = h1; h[2] = h2; h[3] = h3;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      valid = 1; soc = (i == 0);
      data = (i < 4) ? h[i] : base + 8'(i);
      if (i == chg_at) begin mode_wr = 1; mode = chg_mode; end
      else mode_wr = 0;
    end
    @(negedge clk); valid = 0; soc = 0; mode_wr = 0;
    @(negedge clk); #1;
  endtask

  task automatic t_reset;
    chk("R1 buf_we", buf_we, 0);
    chk("R1 q_push", q_push, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 err", act_err, 0);
  endtask

  task automatic t_activation;
    @(negedge clk); port_act = 1;
    repeat (HOLD - 1) @(negedge clk);
    mode = 2'b01; mode_wr = 1;
    @(negedge clk); mode_wr = 0; #1;
    chk("R9 early active refused mode", mode_o, 0);
    chk("R9 early active err", act_err, 1);
    @(negedge clk); mode = 2'b01; mode_wr = 1;
    @(negedge clk); mode_wr = 0; #1;
    chk("R9 active after hold", mode_o, 1);
    @(negedge clk); port_act = 0;
    @(negedge clk); #1;
    chk("R10 drop forces inactive", mode_o, 0);
    chk("R10 drop clears err", act_err, 0);
    write_mode(2'b01);
    chk("R10 write ignored while port off", mode_o, 0);
    @(negedge clk); port_act = 1;
    repeat (HOLD + 2) @(negedge clk);
    write_mode(2'b01);
    chk("R9 reactivated", mode_o, 1);
    chk("R9 no err", act_err, 0);
  endtask

  task automatic t_active_cell;
    int w0 = wr_cnt, p0 = push_cnt;
    send_cell(8'h12, 8'h34, 8'h56, 8'h78, 8'h40, 53, -1, 2'b00);
    chk("R4 writes per cell", wr_cnt - w0, 53);
    chk("R5 one push", push_cnt - p0, 1);
    chk("R5 push slot", last_push, exp_slot);
    chk("R4 byte0 data", shadow[exp_slot*64 + 0], 8'h12);
    chk("R4 byte3 data", shadow[exp_slot*64 + 3], 8'h78);
    chk("R4 byte52 data", shadow[exp_slot*64 + 52], 8'h40 + 8'd52);
    exp_slot = (exp_slot + 1) % NSLOT;
  endtask

  task automatic t_decode;
    write_mode(2'b11); chk("R2 code 11 active", mode_o, 1);
    write_mode(2'b10); chk("R2 code 10 standby", mode_o, 2);
    write_mode(2'b00); chk("R2 code 00 inactive", mode_o, 0);
    write_mode(2'b01); chk("R2 code 01 active", mode_o, 1);
  endtask

  task automatic t_filter;
    int p0;
    del_en = 1; mask = 8'hFE; pat = 8'h00;
    p0 = push_cnt;
    send_cell(8'h00, 8'h00, 8'h00, 8'h01, 8'h10, 53, -1, 2'b00);
    chk("R7 unassigned dropped", push_cnt - p0, 0);
    send_cell(8'h00, 8'h00, 8'h00, 8'h10, 8'h20, 53, -1, 2'b00);
    chk("R7 mismatch kept", push_cnt - p0, 1);
    chk("R7 slot reused after drop", last_push, exp_slot);
    exp_slot = (exp_slot + 1) % NSLOT;
    send_cell(8'h00, 8'h00, 8'h01, 8'h00, 8'h30, 53, -1, 2'b00);
    chk("R7 nonzero lead octets kept", push_cnt - p0, 2);
    chk("R7 slot", last_push, exp_slot);
    exp_slot = (exp_slot + 1) % NSLOT;
    mask = 8'h0F; pat = 8'h05; p0 = push_cnt;
    send_cell(8'h00, 8'h00, 8'h00, 8'hA5, 8'h50, 53, -1, 2'b00);
    chk("R7 masked bits ignored drop", push_cnt - p0, 0);
  endtask

  task automatic t_no_delete;
    int p0 = push_cnt;
    del_en = 0; mask = 8'hFE; pat = 8'h00;
    send_cell(8'h00, 8'h00, 8'h00, 8'h01, 8'h60, 53, -1, 2'b00);
    chk("R8 idle kept when disabled", push_cnt - p0, 1);
    chk("R8 slot", last_push, exp_slot);
    exp_slot = (exp_slot + 1) % NSLOT;
    send_cell(8'h01, 8'h02, 8'h03, 8'h04, 8'h70, 53, -1, 2'b00);
    chk("R5 slot wraps", last_push, exp_slot);
    exp_slot = (exp_slot + 1) % NSLOT;
  endtask

  task automatic t_standby;
    int w0, p0;
    write_mode(2'b10);
    w0 = wr_cnt; p0 = push_cnt;
    send_cell(8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 53, -1, 2'b00);
    chk("R6 standby no write", wr_cnt - w0, 0);
    chk("R6 standby no push", push_cnt - p0, 0);
  endtask

  task automatic t_inactive;
    int w0, p0;
    write_mode(2'b00);
    w0 = wr_cnt; p0 = push_cnt;
    send_cell(8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 53, -1, 2'b00);
    chk("R3 inactive no write", wr_cnt - w0, 0);
    chk("R3 inactive no push", push_cnt - p0, 0);
  endtask

  task automatic t_midcell;
    int w0, p0;
    write_mode(2'b01);
    p0 = push_cnt;
    send_cell(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h80, 53, 10, 2'b10);
    chk("R11 cell finishes in start mode", push_cnt - p0, 1);
    chk("R3 slot untouched by inactive/standby", last_push, exp_slot);
    exp_slot = (exp_slot + 1) % NSLOT;
    chk("R11 new mode in force", mode_o, 2);
    w0 = wr_cnt;
    send_cell(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h80, 53, -1, 2'b00);
    chk("R11 next cell uses standby", wr_cnt - w0, 0);
  endtask

  task automatic t_soc_restart;
    int w0, p0;
    write_mode(2'b01);
    w0 = wr_cnt; p0 = push_cnt;
    send_cell(8'h99, 8'h99, 8'h99, 8'h99, 8'hC0, 20, -1, 2'b00);
    send_cell(8'h21, 8'h22, 8'h23, 8'h24, 8'h90, 53, -1, 2'b00);
    chk("R12 writes partial plus full", wr_cnt - w0, 73);
    chk("R12 one push", push_cnt - p0, 1);
    chk("R12 slot", last_push, exp_slot);
    chk("R12 byte0 restarted", shadow[exp_slot*64 + 0], 8'h21);
    chk("R12 byte52", shadow[exp_slot*64 + 52], 8'h90 + 8'd52);
    exp_slot = (exp_slot + 1) % NSLOT;
  endtask

  task automatic t_port_drop;
    int w0;
    @(negedge clk); port_act = 0;
    @(negedge clk); #1;
    chk("R10 inactive after drop", mode_o, 0);
    w0 = wr_cnt;
    send_cell(8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 53, 5, 2'b01);
    chk("R10 no write while off", wr_cnt - w0, 0);
    chk("R10 mode write ignored", mode_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset;
    rst_n = 1;
    @(negedge clk); #1; t_reset;
    t_activation;
    t_active_cell;
    t_decode;
    t_filter;
    t_no_delete;
    t_standby;
    t_inactive;
    t_midcell;
    t_soc_restart;
    t_port_drop;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule